// File: doc/BRIEF.md
# Special Function Register Write Unit

This block holds a bank of 16-bit control registers and decides, for every write, which bits of the addressed register take new values and which are cleared or kept. A writer presents a register index, an access mode, a byte-lane select, a write word, and an 8-bit mask and data pair for bit-field operations. Plain byte writes put the byte into one lane and clear the other lane. Only the two bit-field modes keep the old value of the bits they do not touch. A combinational read port returns any register's contents.

Each register has a static implemented-bit mask, set by a parameter. Positions outside the mask are reserved. A reserved position never stores a 1 and always reads 0, so a 1 written there later has no effect on the stored value. Writes and reads carry no handshake. A write is taken at the rising clock edge, and the result is visible on the read port after that edge.

Top module: `sfr_write_unit`

## Requirements
- R1: While reset is asserted and after it is released, every register reads 0x0000.
- R2: Word mode (code 0) replaces every implemented bit of the register with `wr_data` at one clock edge.
- R3: Byte mode with long addressing (code 1) writes `wr_data[7:0]` into the lane chosen by `wr_hi` (0 = bits 7:0, 1 = bits 15:8) and clears the other lane.
- R4: Byte transfer mode (code 2) behaves exactly like code 1: the selected lane gets `wr_data[7:0]` and the other lane is cleared.
- R5: Short byte mode (code 3) always writes `wr_data[7:0]` into bits 7:0 and clears bits 15:8, whatever the value of `wr_hi`.
- R6: Bit-field low mode (code 4) sets bits 7:0 to (old & ~bf_mask) | (bf_data & bf_mask) and leaves bits 15:8 unchanged.
- R7: Bit-field high mode (code 5) applies the same merge to bits 15:8 and leaves bits 7:0 unchanged.
- R8: Reserved bits (zeros in the register's implemented-bit mask) always read 0, even after a 1 is written to them in any mode.
- R9: A write presented while reset is asserted is ignored.
- R10: A write with `wr_en` low or with an undefined mode code (6 or 7) changes no register, and a write changes no register other than the indexed one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | 3 | Index of the register to write |
| wr_mode | input | 3 | Access mode code (0 to 5; 6 and 7 undefined) |
| wr_hi | input | 1 | Byte-lane select for byte modes 1 and 2 |
| wr_data | input | 16 | Write word; byte modes use bits 7:0 |
| bf_mask | input | 8 | Bit-field select mask for modes 4 and 5 |
| bf_data | input | 8 | Bit-field values for modes 4 and 5 |
| rd_idx | input | 3 | Index of the register to read |
| rd_data | output | 16 | Contents of the register at `rd_idx` |

## Verification
Because the read port is combinational, a wrong stored value shows on `rd_data` in the first cycle after the faulty write. It can only be seen by selecting that register. So every write is followed by a read of the same index, and other registers are read back to catch a write that landed in the wrong place. A merge that used the wrong lane or dropped the inverted mask leaves bits that should have been kept set or cleared. A reserved bit that stored a 1 shows as a set bit outside the register's mask. Both can be seen in a single read.

// File: rtl/sfr_wr_pkg.sv
package sfr_wr_pkg;

   localparam int WORD_W = 16;
   localparam int LANE_W = 8;
   localparam int LANES  = WORD_W / LANE_W;
   localparam int MODE_W = 3;

   // Access mode codes; values 6 and 7 are undefined and write nothing.
   typedef enum logic [MODE_W-1:0] {
      MODE_WORD       = 3'd0,
      MODE_BYTE_LONG  = 3'd1,
      MODE_BYTE_XFER  = 3'd2,
      MODE_BYTE_SHORT = 3'd3,
      MODE_BITS_LO    = 3'd4,
      MODE_BITS_HI    = 3'd5
   } sfr_mode_e;

   // Decoded write: bits set in keep retain the old value, ins supplies new ones.
   typedef struct packed {
      logic              valid;
      logic [WORD_W-1:0] keep;
      logic [WORD_W-1:0] ins;
   } sfr_wr_op_t;

endpackage

// File: rtl/sfr_wr_decode.sv
module sfr_wr_decode
   import sfr_wr_pkg::*;
(
   input  logic [MODE_W-1:0] mode_i,
   input  logic              hi_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic [LANE_W-1:0] bf_mask_i,
   input  logic [LANE_W-1:0] bf_data_i,
   output sfr_wr_op_t        op_o
);

   localparam logic [LANE_W-1:0] LANE_ZERO = '0;
   localparam logic [LANE_W-1:0] LANE_ONES = '1;

   logic [LANE_W-1:0] byte_val;
   logic [LANE_W-1:0] bf_set;
   logic [WORD_W-1:0] byte_lo_word;
   logic [WORD_W-1:0] byte_hi_word;

   assign byte_val     = data_i[LANE_W-1:0];
   assign bf_set       = bf_data_i & bf_mask_i;
   assign byte_lo_word = {LANE_ZERO, byte_val};
   assign byte_hi_word = {byte_val, LANE_ZERO};

   always_comb begin
      op_o.valid = 1'b0;
      op_o.keep  = '1;
      op_o.ins   = '0;
      case (mode_i)
         MODE_WORD: begin
            op_o.valid = 1'b1;
            op_o.keep  = '0;
            op_o.ins   = data_i;
         end
         MODE_BYTE_LONG, MODE_BYTE_XFER: begin
            op_o.valid = 1'b1;
            op_o.keep  = '0;
            op_o.ins   = hi_i ? byte_hi_word : byte_lo_word;
         end
         MODE_BYTE_SHORT: begin
            op_o.valid = 1'b1;
            op_o.keep  = '0;
            op_o.ins   = byte_lo_word;
         end
         MODE_BITS_LO: begin
            op_o.valid = 1'b1;
            op_o.keep  = {LANE_ONES, ~bf_mask_i};
            op_o.ins   = {LANE_ZERO, bf_set};
         end
         MODE_BITS_HI: begin
            op_o.valid = 1'b1;
            op_o.keep  = {~bf_mask_i, LANE_ONES};
            op_o.ins   = {bf_set, LANE_ZERO};
         end
         default: begin
            op_o.valid = 1'b0;
         end
      endcase
   end

   // R6/R7: a bit may not be both kept and inserted.
   always_comb begin
      p_keep_ins_disjoint_r6: assert (!op_o.valid || ((op_o.keep & op_o.ins) == '0))
         else $error("decode keeps and inserts the same bit");
   end

endmodule

// File: rtl/sfr_wr_cell.sv
module sfr_wr_cell
   import sfr_wr_pkg::*;
#(
   parameter logic [WORD_W-1:0] IMPL = '1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [WORD_W-1:0] keep_i,
   input  logic [WORD_W-1:0] ins_i,
   output logic [WORD_W-1:0] q_o
);

   logic [WORD_W-1:0] merged;

   assign merged = ((q_o & keep_i) | ins_i) & IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (we_i) begin
         q_o <= merged;
      end
   end

   // R10: an unselected register holds its value.
   p_hold_unselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o))
      else $error("register changed without a write");

endmodule

// File: rtl/sfr_wr_rdmux.sv
module sfr_wr_rdmux
   import sfr_wr_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int IDX_W    = 3
)(
   input  logic [WORD_W-1:0] regs_i [NUM_REGS],
   input  logic [IDX_W-1:0]  idx_i,
   output logic [WORD_W-1:0] data_o
);

   always_comb begin
      data_o = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(idx_i) == i) begin
            data_o = regs_i[i];
         end
      end
   end

endmodule

// File: rtl/sfr_write_unit.sv
module sfr_write_unit
   import sfr_wr_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter logic [NUM_REGS*16-1:0] IMPL_MASK =
      128'hFFFF_A5A5_FF00_00FF_FF0F_0FF0_7FFF_FFFF,
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [2:0]        wr_mode,
   input  logic              wr_hi,
   input  logic [15:0]       wr_data,
   input  logic [7:0]        bf_mask,
   input  logic [7:0]        bf_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [15:0]       rd_data
);

   generate
      if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_count
         $error("NUM_REGS must lie in 1..256");
      end
      if (WORD_W != LANES * LANE_W || WORD_W != 16) begin : g_bad_width
         $error("register word must be two 8-bit lanes");
      end
   endgenerate

   function automatic logic [WORD_W-1:0] impl_of(input int i);
      return IMPL_MASK[i*WORD_W +: WORD_W];
   endfunction

   sfr_wr_op_t        op;
   logic              in_range;
   logic              fire;
   logic [NUM_REGS-1:0] we;
   logic [WORD_W-1:0] q_arr [NUM_REGS];

   sfr_wr_decode i_decode (
      .mode_i    (wr_mode),
      .hi_i      (wr_hi),
      .data_i    (wr_data),
      .bf_mask_i (bf_mask),
      .bf_data_i (bf_data),
      .op_o      (op)
   );

   assign in_range = (int'(wr_idx) < NUM_REGS);
   assign fire     = wr_en & op.valid & in_range;

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         assign we[g] = fire && (int'(wr_idx) == g);

         sfr_wr_cell #(
            .IMPL (IMPL_MASK[g*WORD_W +: WORD_W])
         ) i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_i   (we[g]),
            .keep_i (op.keep),
            .ins_i  (op.ins),
            .q_o    (q_arr[g])
         );
      end
   endgenerate

   sfr_wr_rdmux #(
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) i_rdmux (
      .regs_i (q_arr),
      .idx_i  (rd_idx),
      .data_o (rd_data)
   );

   // ---------------- assertions ----------------
   p_word_replace_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range && wr_mode == MODE_WORD) |=>
      q_arr[$past(wr_idx)] == ($past(wr_data) & impl_of(int'($past(wr_idx)))))
      else $error("word write result wrong");

   p_byte_hi_clears_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range && wr_hi &&
       (wr_mode == MODE_BYTE_LONG || wr_mode == MODE_BYTE_XFER)) |=>
      q_arr[$past(wr_idx)][LANE_W-1:0] == '0)
      else $error("high byte write left low lane set");

   p_byte_lo_clears_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range && !wr_hi &&
       (wr_mode == MODE_BYTE_LONG || wr_mode == MODE_BYTE_XFER)) |=>
      q_arr[$past(wr_idx)][WORD_W-1:LANE_W] == '0)
      else $error("low byte write left high lane set");

   p_short_clears_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range && wr_mode == MODE_BYTE_SHORT) |=>
      q_arr[$past(wr_idx)][WORD_W-1:LANE_W] == '0)
      else $error("short byte write left high lane set");

   p_bits_lo_keeps_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range && wr_mode == MODE_BITS_LO) |=>
      q_arr[$past(wr_idx)][WORD_W-1:LANE_W] ==
      $past(q_arr[wr_idx][WORD_W-1:LANE_W]))
      else $error("low bit-field write changed high lane");

   p_bits_hi_keeps_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range && wr_mode == MODE_BITS_HI) |=>
      q_arr[$past(wr_idx)][LANE_W-1:0] == $past(q_arr[wr_idx][LANE_W-1:0]))
      else $error("high bit-field write changed low lane");

   p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_idx) < NUM_REGS) |->
      ((rd_data & ~impl_of(int'(rd_idx))) == '0))
      else $error("reserved bit reads as one");

endmodule

// File: tb/test_sfr_write_unit.sv
module test_sfr_write_unit;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [2:0]  wr_mode = '0;
   logic        wr_hi = 1'b0;
   logic [15:0] wr_data = '0;
   logic [7:0]  bf_mask = '0;
   logic [7:0]  bf_data = '0;
   logic [2:0]  rd_idx = '0;
   logic [15:0] rd_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfr_write_unit i_sfr_write_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_mode (wr_mode),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .bf_mask (bf_mask),
      .bf_data (bf_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  idx;
      logic [2:0]  mode;
      logic        hi;
      logic [15:0] wd;
      logic [7:0]  m;
      logic [7:0]  d;
      logic [15:0] exp;
   } vec_t;

   // Implemented masks: r0 FFFF r1 7FFF r2 0FF0 r3 FF0F r4 00FF r5 FF00 r6 A5A5 r7 FFFF
   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{4'd2,  3'd0, 3'd0, 1'b0, 16'h1234, 8'h00, 8'h00, 16'h1234}, // R2
      '{4'd3,  3'd0, 3'd1, 1'b1, 16'h77AB, 8'h00, 8'h00, 16'hAB00}, // R3
      '{4'd2,  3'd0, 3'd0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 16'hFFFF}, // R2
      '{4'd3,  3'd0, 3'd1, 1'b0, 16'h995A, 8'h00, 8'h00, 16'h005A}, // R3
      '{4'd2,  3'd7, 3'd0, 1'b0, 16'hBEEF, 8'h00, 8'h00, 16'hBEEF}, // R2
      '{4'd4,  3'd7, 3'd2, 1'b1, 16'h0011, 8'h00, 8'h00, 16'h1100}, // R4
      '{4'd2,  3'd7, 3'd0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 16'hFFFF}, // R2
      '{4'd4,  3'd7, 3'd2, 1'b0, 16'hFF66, 8'h00, 8'h00, 16'h0066}, // R4
      '{4'd2,  3'd7, 3'd0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 16'hFFFF}, // R2
      '{4'd5,  3'd7, 3'd3, 1'b1, 16'hAA3C, 8'h00, 8'h00, 16'h003C}, // R5
      '{4'd8,  3'd1, 3'd0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 16'h7FFF}, // R8
      '{4'd6,  3'd1, 3'd4, 1'b0, 16'h0000, 8'h0F, 8'hA5, 16'h7FF5}, // R6
      '{4'd7,  3'd1, 3'd5, 1'b0, 16'h0000, 8'hF0, 8'h00, 16'h0FF5}, // R7
      '{4'd8,  3'd6, 3'd0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 16'hA5A5}, // R8
      '{4'd8,  3'd6, 3'd5, 1'b0, 16'h0000, 8'hFF, 8'hFF, 16'hA5A5}, // R8
      '{4'd6,  3'd6, 3'd4, 1'b0, 16'h0000, 8'hFF, 8'h00, 16'hA500}, // R6
      '{4'd8,  3'd2, 3'd0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 16'h0FF0}, // R8
      '{4'd10, 3'd2, 3'd6, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h0FF0}, // R10
      '{4'd8,  3'd3, 3'd0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 16'hFF0F}, // R8
      '{4'd6,  3'd3, 3'd4, 1'b0, 16'h0000, 8'h03, 8'h00, 16'hFF0C}, // R6
      '{4'd10, 3'd3, 3'd7, 1'b0, 16'h0000, 8'h00, 8'h00, 16'hFF0C}, // R10
      '{4'd8,  3'd4, 3'd0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 16'h00FF}  // R8
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic write_op(input logic [2:0] idx, input logic [2:0] mode, input logic hi,
                           input logic [15:0] wd, input logic [7:0] m, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_mode = mode; wr_hi = hi;
      wr_data = wd; bf_mask = m; bf_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic [2:0] idx, input logic [15:0] exp);
      rd_idx = idx;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      // R1 and R9: reset state, with a write held during reset
      wr_en = 1'b1; wr_idx = 3'd0; wr_mode = 3'd0; wr_data = 16'h1234;
      repeat (3) @(negedge clk);
      read_chk("R1", 3'd0, 16'h0000);
      wr_en = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) read_chk("R1", 3'(i), 16'h0000);
      read_chk("R9", 3'd0, 16'h0000);

      // table walk: each write then a read of the same register
      for (int v = 0; v < NV; v++) begin
         write_op(VECS[v].idx, VECS[v].mode, VECS[v].hi, VECS[v].wd, VECS[v].m, VECS[v].d);
         read_chk($sformatf("R%0d", VECS[v].req), VECS[v].idx, VECS[v].exp);
      end

      // R8: byte write of ones into the reserved low lane of r5
      write_op(3'd5, 3'd1, 1'b0, 16'h00FF, 8'h00, 8'h00);
      read_chk("R8", 3'd5, 16'h0000);

      // R10: wr_en low leaves r4 alone
      @(negedge clk);
      wr_idx = 3'd4; wr_mode = 3'd0; wr_data = 16'h0000; wr_en = 1'b0;
      @(negedge clk);
      read_chk("R10", 3'd4, 16'h00FF);

      // R10: write to r4 leaves neighbours untouched
      write_op(3'd4, 3'd0, 1'b0, 16'h0012, 8'h00, 8'h00);
      read_chk("R2", 3'd4, 16'h0012);
      read_chk("R10", 3'd3, 16'hFF0C);
      read_chk("R10", 3'd5, 16'h0000);
      read_chk("R10", 3'd0, 16'h005A);

      // R1: reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) read_chk("R1", 3'(i), 16'h0000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule